// File: doc/BRIEF.md
# Virtualized Predictor Table Proxy

This block stands between a spatial-pattern prefetch predictor and the L2 memory port. The predictor's full table lives in ordinary memory. The block serves lookups and updates from an eight-line on-chip cache and fetches backing lines through one outstanding memory request.

Each request carries a 16-bit PC and a 5-bit offset within a 32-block spatial group. These form a 21-bit key, and the key splits into a 10-bit table set index and an 11-bit entry tag. One 64-byte memory line holds one table set: eleven entries, each an 11-bit tag with a 32-bit pattern (one bit per block of the group). The line is fetched from a programmable base address plus the set index times 64. A lookup returns the pattern of the matching entry. An update rewrites the matching entry, or else a round-robin victim, and marks the cached line dirty. A dirty line that must give way is written back before the new line is read.

Requests use a ready/valid handshake. The block accepts a new request only after it has answered the previous one.

Top module: `ptp_proxy`

## Requirements
- R1: The key is {pc, off}. The set index is key[9:0], i.e. {pc[4:0], off}, and the entry tag is key[20:10], i.e. pc[15:5]. The on-chip cache line is chosen by index[2:0], and index[9:3] is kept as that line's tag.
- R2: Entry w (0..10) of a line occupies bits [43w+42 : 43w], with the tag in the upper 11 bits and the pattern in the lower 32. Bits 511:473 are carried unchanged from fill to write-back.
- R3: A lookup reports rsp_hit=1 with the pattern of the lowest-numbered entry whose tag matches and whose pattern is nonzero. Otherwise it reports rsp_hit=0 and a zero pattern. An entry with a zero pattern counts as empty.
- R4: An update with a matching entry overwrites that entry's pattern and reports rsp_hit=1. Without a match, it writes tag and pattern into the entry named by a per-cache-line round-robin pointer (reset 0, advancing modulo 11 on each such write) and reports rsp_hit=0. In both cases rsp_pattern echoes the written pattern and the line becomes dirty.
- R5: The memory address of table set i is base_addr + i*64.
- R6: A request whose set is not cached issues exactly one read of that set's address. The request is answered only after the read data has returned.
- R7: When the displaced line is dirty, a write of its contents to its own set address precedes the fill read. A clean line is dropped with no write.
- R8: req_ready is low from the cycle after a request is accepted until its response. A memory request holds its valid, address and write flag until accepted.
- R9: After reset, req_ready=1, rsp_valid=0 and mem_req_valid=0, and no cache line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 32 | Start address of the memory-resident table |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = update, 0 = lookup |
| req_pc | input | 16 | PC part of the key |
| req_off | input | 5 | Offset within the spatial group |
| req_pattern | input | 32 | Pattern written by an update |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Matching entry found |
| rsp_pattern | output | 32 | Looked-up or written pattern |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write-back, 0 = line read |
| mem_req_addr | output | 32 | Byte address of the line |
| mem_req_wdata | output | 512 | Write-back line |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 512 | Read line |

## Verification
The bench sweeps many table sets through every cache line, mixing lookups and updates so that lines are refilled, dirtied and evicted repeatedly. Write-back data is compared against an arithmetic model of the logical table. A wrong entry slice or lost unused bits would show as corrupted patterns after a round trip through memory. A skipped write-back would make later lookups return stale memory contents, and a write-back of a clean line would show as an unexpected memory write. The sweep also looks up the tags of empty entries, which a design ignoring the zero-pattern rule would report as hits. It tracks the round-robin pointer per line, which exposes a shared or wrongly wrapping pointer.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WB, S_FILL, S_WAIT, S_REREAD
  } ptp_state_e;
endpackage

// File: rtl/ptp_line_ram.sv
module ptp_line_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ptp_way_match.sv
module ptp_way_match #(
  parameter int WAYS  = 11,
  parameter int TAG_W = 11,
  parameter int PAT_W = 32,
  localparam int ENT_W = TAG_W + PAT_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS*ENT_W-1:0] packed_line,
  input  logic [TAG_W-1:0]      key_tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way,
  output logic [PAT_W-1:0]      hit_pat
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic [TAG_W-1:0] e_tag;
    logic [PAT_W-1:0] e_pat;
    assign e_tag    = packed_line[w*ENT_W+PAT_W +: TAG_W];
    assign e_pat    = packed_line[w*ENT_W +: PAT_W];
    assign match[w] = (e_tag == key_tag) && (e_pat != '0);
  end

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    hit_pat = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
        hit_pat = packed_line[w*ENT_W +: PAT_W];
      end
    end
  end
endmodule

// File: rtl/ptp_proxy.sv
module ptp_proxy
  import ptp_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int OFF_W      = 5,
  parameter int IDX_W      = 10,
  parameter int SET_W      = 3,
  parameter int PAT_W      = 32,
  parameter int WAYS       = 11,
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32,
  localparam int KEY_W  = PC_W + OFF_W,
  localparam int TAG_W  = KEY_W - IDX_W,
  localparam int ENT_W  = TAG_W + PAT_W,
  localparam int PACK_W = WAYS * ENT_W,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int BLK_SH = $clog2(LINE_BYTES),
  localparam int LTAG_W = IDX_W - SET_W,
  localparam int SETS   = 1 << SET_W,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [PAT_W-1:0]  req_pattern,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PAT_W-1:0]  rsp_pattern,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_rdata
);
  ptp_state_e state;

  // latched request
  logic              q_write;
  logic [IDX_W-1:0]  q_idx;
  logic [TAG_W-1:0]  q_tag;
  logic [PAT_W-1:0]  q_pat;

  // per-line bookkeeping (flops)
  logic [SETS-1:0]   line_valid;
  logic [SETS-1:0]   line_dirty;
  logic [LTAG_W-1:0] line_tag [SETS];
  logic [WAY_W-1:0]  rr_ptr   [SETS];

  logic [KEY_W-1:0]  req_key;
  logic [SET_W-1:0]  cur_set, rd_set;
  logic [LTAG_W-1:0] cur_ltag;
  logic              line_hit;

  assign req_key  = {req_pc, req_off};
  assign cur_set  = q_idx[SET_W-1:0];
  assign cur_ltag = q_idx[IDX_W-1:SET_W];
  assign rd_set   = (state == S_IDLE) ? req_key[SET_W-1:0] : cur_set;
  assign line_hit = line_valid[cur_set] && (line_tag[cur_set] == cur_ltag);

  // data array
  logic              ram_we;
  logic [LINE_W-1:0] ram_wdata, rd_line, upd_line;

  ptp_line_ram #(.DEPTH(SETS), .WIDTH(LINE_W)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(cur_set),
    .wdata(ram_wdata),
    .raddr(rd_set),
    .rdata(rd_line)
  );

  logic             m_hit;
  logic [WAY_W-1:0] m_way, tgt_way;
  logic [PAT_W-1:0] m_pat;

  ptp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PAT_W(PAT_W)) u_match (
    .packed_line(rd_line[PACK_W-1:0]),
    .key_tag    (q_tag),
    .hit        (m_hit),
    .hit_way    (m_way),
    .hit_pat    (m_pat)
  );

  assign tgt_way = m_hit ? m_way : rr_ptr[cur_set];

  always_comb begin
    upd_line = rd_line;
    upd_line[int'(tgt_way)*ENT_W +: ENT_W] = {q_tag, q_pat};
  end

  assign ram_we    = (state == S_LOOK && line_hit && q_write) ||
                     (state == S_WAIT && mem_rsp_valid);
  assign ram_wdata = (state == S_WAIT) ? mem_rsp_rdata : upd_line;

  // line addresses
  logic [ADDR_W-1:0] fill_addr, wb_addr;
  assign fill_addr = base_addr + (ADDR_W'(q_idx) << BLK_SH);
  assign wb_addr   = base_addr + (ADDR_W'({line_tag[cur_set], cur_set}) << BLK_SH);

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_WB) || (state == S_FILL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      line_valid    <= '0;
      line_dirty    <= '0;
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_pattern   <= '0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      for (int s = 0; s < SETS; s++) rr_ptr[s] <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            q_write <= req_write;
            q_idx   <= req_key[IDX_W-1:0];
            q_tag   <= req_key[KEY_W-1:IDX_W];
            q_pat   <= req_pattern;
            state   <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (line_hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= m_hit;
            if (q_write) begin
              rsp_pattern         <= q_pat;
              line_dirty[cur_set] <= 1'b1;
              if (!m_hit)
                rr_ptr[cur_set] <= (rr_ptr[cur_set] == WAY_W'(WAYS - 1)) ?
                                   '0 : rr_ptr[cur_set] + 1'b1;
            end else begin
              rsp_pattern <= m_hit ? m_pat : '0;
            end
            state <= S_IDLE;
          end else if (line_valid[cur_set] && line_dirty[cur_set]) begin
            mem_req_addr  <= wb_addr;
            mem_req_wdata <= rd_line;
            mem_req_write <= 1'b1;
            state         <= S_WB;
          end else begin
            mem_req_addr  <= fill_addr;
            mem_req_write <= 1'b0;
            state         <= S_FILL;
          end
        end
        S_WB: begin
          if (mem_req_ready) begin
            mem_req_addr  <= fill_addr;
            mem_req_write <= 1'b0;
            state         <= S_FILL;
          end
        end
        S_FILL: begin
          if (mem_req_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            line_valid[cur_set] <= 1'b1;
            line_dirty[cur_set] <= 1'b0;
            line_tag[cur_set]   <= cur_ltag;
            state               <= S_REREAD;
          end
        end
        S_REREAD: state <= S_LOOK;
        default:  state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptp_checker.sv
module ptp_checker #(
  parameter int ADDR_W = 32,
  parameter int BLK_SH = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] base_addr,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr
);
  // R8: accepting a request makes the block busy
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  // R8: no new request is taken while memory traffic is pending
  p_no_accept_during_mem_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  // R8: a stalled memory request keeps its contents
  p_mem_hold_r8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  // R7: an accepted write-back is followed by the fill read
  p_fill_after_wb_r7: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_ready && mem_req_write |=>
      mem_req_valid && !mem_req_write);

  // R5: every memory address is line-aligned relative to the base
  p_addr_align_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> mem_req_addr[BLK_SH-1:0] == base_addr[BLK_SH-1:0]);

  // R6: responses are single-cycle strobes
  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind ptp_proxy ptp_checker #(.ADDR_W(ADDR_W), .BLK_SH(BLK_SH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .base_addr    (base_addr),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_addr (mem_req_addr)
);

// File: tb/ptp_proxy_test.sv
`timescale 1ns/1ps
module ptp_proxy_test;
  localparam logic [31:0] BASE = 32'h8001_0000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  base_addr = BASE;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic         req_ready;
  logic [15:0]  req_pc = '0;
  logic [4:0]   req_off = '0;
  logic [31:0]  req_pattern = '0;
  logic         rsp_valid, rsp_hit;
  logic [31:0]  rsp_pattern;
  logic         mem_req_valid, mem_req_write;
  logic         mem_req_ready = 1'b0;
  logic [31:0]  mem_req_addr;
  logic [511:0] mem_req_wdata;
  logic         mem_rsp_valid = 1'b0;
  logic [511:0] mem_rsp_rdata = '0;

  always #2.5 clk = ~clk;

  ptp_proxy uut (
    .clk(clk), .rst(rst), .base_addr(base_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_pc(req_pc), .req_off(req_off), .req_pattern(req_pattern),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pattern(rsp_pattern),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [511:0] bmem    [1024];   // backing memory
  logic [511:0] ref_tab [1024];   // logical table contents
  bit           res_v [8];
  bit           res_d [8];
  int           res_i [8];
  int           rr_m  [8];

  int wb_n = 0, rd_n = 0, ev = 0, wb_ev = 0, rd_ev = 0;
  logic [31:0]  wb_addr_l, rd_addr_l;
  logic [511:0] wb_data_l;

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] init_line(input int i);
    logic [511:0] l;
    l = '0;
    for (int w = 0; w < 11; w++) begin
      logic [10:0] t;
      logic [31:0] p;
      t = 11'((w * 97 + i) & 2047);
      p = (32'(i) * 32'h9E37_79B9) ^ (32'(w) * 32'h0101_0101 + 32'd1);
      if (w == 10 && (i % 3) == 0) p = '0;
      l[w*43 +: 43] = {t, p};
    end
    l[511:473] = 39'(i * 5 + 3);
    return l;
  endfunction

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic        w;
        logic [31:0] a;
        logic [511:0] d;
        w = mem_req_write; a = mem_req_addr; d = mem_req_wdata;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        ev++;
        if (w) begin
          wb_n++; wb_ev = ev; wb_addr_l = a; wb_data_l = d;
          bmem[10'((a - BASE) >> 6)] = d;
        end else begin
          rd_n++; rd_ev = ev; rd_addr_l = a;
          @(negedge clk);
          mem_rsp_rdata = bmem[10'((a - BASE) >> 6)];
          mem_rsp_valid = 1'b1;
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  task automatic do_op(input bit wr, input logic [15:0] pc, input logic [4:0] off,
                       input logic [31:0] pat);
    int idx, set, wb0, rd0, way;
    bit miss, exp_wb, found, ready_low;
    logic [10:0] tg;
    logic [31:0] exp_pat;
    idx = int'({pc[4:0], off});
    set = idx & 7;
    tg  = pc[15:5];
    miss   = !(res_v[set] && res_i[set] == idx);
    exp_wb = miss && res_v[set] && res_d[set];
    wb0 = wb_n; rd0 = rd_n;
    found = 0; way = 0;
    for (int w = 10; w >= 0; w--)
      if (ref_tab[idx][w*43+32 +: 11] == tg && ref_tab[idx][w*43 +: 32] != 0) begin
        found = 1; way = w;
      end
    exp_pat = found ? ref_tab[idx][way*43 +: 32] : 32'd0;
    // drive request
    @(negedge clk);
    req_valid = 1; req_write = wr; req_pc = pc; req_off = off; req_pattern = pat;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    ready_low = 1;
    while (!rsp_valid) begin
      if (req_ready) ready_low = 0;
      @(negedge clk);
    end
    chk(ready_low, "R8 ready low while busy", 512'(ready_low), 512'd1);
    chk(rd_n - rd0 == int'(miss), "R6 fill read count", 512'(rd_n - rd0), 512'(miss));
    if (miss)
      chk(rd_addr_l == BASE + 32'(idx) * 64, "R1 R5 fill address", 512'(rd_addr_l),
          512'(BASE + 32'(idx) * 64));
    chk(wb_n - wb0 == int'(exp_wb), "R7 write-back count", 512'(wb_n - wb0), 512'(exp_wb));
    if (exp_wb) begin
      chk(wb_addr_l == BASE + 32'(res_i[set]) * 64, "R7 write-back address",
          512'(wb_addr_l), 512'(BASE + 32'(res_i[set]) * 64));
      chk(wb_data_l == ref_tab[res_i[set]], "R2 R7 write-back data", wb_data_l,
          ref_tab[res_i[set]]);
      chk(wb_ev < rd_ev, "R7 write-back before fill", 512'(wb_ev), 512'(rd_ev));
    end
    chk(rsp_hit == found, wr ? "R4 update hit flag" : "R3 lookup hit flag",
        512'(rsp_hit), 512'(found));
    if (wr) begin
      chk(rsp_pattern == pat, "R4 update echo", 512'(rsp_pattern), 512'(pat));
      if (!found) begin
        way = rr_m[set];
        rr_m[set] = (rr_m[set] + 1) % 11;
      end
      ref_tab[idx][way*43 +: 43] = {tg, pat};
    end else begin
      chk(rsp_pattern == exp_pat, "R3 lookup pattern", 512'(rsp_pattern), 512'(exp_pat));
    end
    if (miss) begin
      res_v[set] = 1; res_i[set] = idx; res_d[set] = 0;
    end
    if (wr) res_d[set] = 1;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      bmem[i] = init_line(i);
      ref_tab[i] = bmem[i];
    end
    for (int s = 0; s < 8; s++) begin
      res_v[s] = 0; res_d[s] = 0; res_i[s] = 0; rr_m[s] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1, "R9 reset ready", 512'(req_ready), 512'd1);
    chk(rsp_valid == 0, "R9 reset rsp_valid", 512'(rsp_valid), 512'd0);
    chk(mem_req_valid == 0, "R9 reset mem_req_valid", 512'(mem_req_valid), 512'd0);

    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int k = 0; k < 128; k++) begin
        int idx, w;
        logic [10:0] tg;
        logic [31:0] pat;
        idx = (k * 37 + rnd * 8) & 1023;
        if (rnd >= 2) idx = ((k & 15) + 8 * ((k >> 4) + rnd)) & 1023;
        w   = (k + rnd) % 11;
        tg  = ref_tab[idx][w*43+32 +: 11];
        if (((k + rnd) % 5) == 4) tg = 11'(2047 - k);
        pat = (32'(idx) * 32'd977 + 32'(rnd) * 32'd31) | 32'd1;
        case ((k + rnd) % 3)
          0: do_op(0, {tg, 5'(idx >> 5)}, 5'(idx), 32'd0);
          1: do_op(1, {tg, 5'(idx >> 5)}, 5'(idx), pat);
          default: begin
            do_op(1, {tg, 5'(idx >> 5)}, 5'(idx), pat ^ 32'h5A00_0000);
            do_op(0, {tg, 5'(idx >> 5)}, 5'(idx), 32'd0);
          end
        endcase
      end
    end
    // empty entries: zero-pattern way must not hit (R3)
    for (int i = 0; i < 48; i += 3) begin
      int idx;
      idx = 600 + i;
      if ((idx % 3) == 0 && ref_tab[idx][10*43 +: 32] == 0)
        do_op(0, {ref_tab[idx][10*43+32 +: 11], 5'(idx >> 5)}, 5'(idx), 32'd0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule